// File: doc/BRIEF.md
# MMIO Window to Partition Decoder

This block takes a CPU-side MMIO address and decides which outbound window claims it, what address goes onto PCIe, and which isolation partition (PE number) owns the access. It has sixteen 64-bit windows and one 32-bit window. A 64-bit window forwards the address unchanged. Its PE comes either from a single programmed value or, in segmented mode, from the index of the 1/256 slice of the window that the address falls in. The 32-bit window replaces the address bits above its size with a programmed value, and it looks its PE up in a 256-entry table indexed by segment.

Software programs the windows and the table through a simple register write port. The lookup address is registered once, and the hit flag, the translated address and the PE number are then formed combinationally from that register. When windows overlap, the lowest-numbered 64-bit window that hits wins. The 32-bit window is used only when no 64-bit window hits.

Top module: `mmio_pe_decoder`

## Requirements
- R1: After reset, every window is disabled and every table entry is 0, so any address gives hit=0, pe=0 and pci_addr=0.
- R2: The outputs reflect the `req_addr` sampled at the most recent rising clock edge and do not change between edges.
- R3: A write with `cfg_we`=1 is decoded from `cfg_addr` (10 bits). 0x000-0x0FF writes table entry `cfg_addr[7:0]` with `cfg_wdata[7:0]`. 0x100 writes the 32-bit window base. 0x101 writes the 32-bit window control: bit 0 enable, bits 13:8 log2 size. 0x102 writes the replacement value. 0x200+2w writes the base of 64-bit window w. 0x201+2w writes its control: bit 0 enable, bit 1 segmented, bits 13:8 log2 size, bits 23:16 PE. Writes to any other address change nothing.
- R4: A 64-bit window of log2 size s claims an address whose bits 63:s equal the base's bits 63:s. The base bits below s are ignored. A programmed size is clamped to the range 28..63.
- R5: When a 64-bit window wins, pci_addr equals the request address.
- R6: An unsegmented 64-bit window reports its programmed PE for every address it claims.
- R7: A segmented 64-bit window reports PE = address bits [s-1:s-8] and ignores its programmed PE field.
- R8: Among 64-bit windows that claim the same address, the lowest-numbered one wins.
- R9: The 32-bit window is used only when no enabled 64-bit window claims the address.
- R10: The 32-bit window of log2 size s (clamped to 8..32) claims an address matching its base above bit s-1. Its pci_addr takes bits 63:s from the replacement value and bits s-1:0 from the request.
- R11: The 32-bit window's PE is the table entry indexed by address bits [s-1:s-8].
- R12: The topmost 64 KB of the 32-bit window decodes like any other part of it.
- R13: On a miss, hit=0, pe=0 and pci_addr=0.
- R14: A disabled window never claims an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration register address |
| cfg_wdata | input | 64 | Configuration write data |
| req_addr | input | 64 | CPU-side MMIO address to decode |
| hit | output | 1 | Some window claims the registered address |
| pci_addr | output | 64 | Translated PCIe address |
| pe | output | 8 | Owning PE number |

## Verification
A configuration write takes effect at the rising edge where `cfg_we` is seen. A lookup address presented before a rising edge produces its hit, translated address and PE right after that edge, so every result is due one cycle after its stimulus. The bench drives writes and addresses at the falling edge and samples the outputs at the next falling edge, after exactly one rising edge. The latency test also samples just after the address changes, before the edge, and expects the previous result still to be there. Each expected value is worked out by hand from the window bases, sizes and table contents that the test has programmed.

// File: rtl/mmio_pe_pkg.sv
package mmio_pe_pkg;
  localparam int ADDR_W       = 64;
  localparam int PE_W         = 8;
  localparam int SEG_W        = 8;
  localparam int SZ_W         = $clog2(ADDR_W);
  localparam int CFG_AW       = 10;
  localparam int W64_MIN_LOG2 = 28;
  localparam int W32_MAX_LOG2 = 32;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PE_W-1:0]   pe_t;
  typedef logic [SZ_W-1:0]   sz_t;
  typedef logic [SEG_W-1:0]  seg_t;

  typedef struct packed {
    logic  en;
    logic  seg_mode;
    sz_t   sz;
    pe_t   pe;
    addr_t base;
  } w64_cfg_t;

  typedef struct packed {
    logic  en;
    sz_t   sz;
    addr_t base;
    addr_t repl;
  } w32_cfg_t;

  // ones below bit s
  function automatic addr_t low_mask(sz_t s);
    return ~({ADDR_W{1'b1}} << s);
  endfunction

  // naturally aligned region test
  function automatic logic in_region(addr_t a, addr_t b, sz_t s);
    return ((a ^ b) & ~low_mask(s)) == '0;
  endfunction

  // top SEG_W bits of the offset inside a 2^s region
  function automatic seg_t seg_of(addr_t a, sz_t s);
    return SEG_W'(a >> (s - sz_t'(SEG_W)));
  endfunction

  function automatic sz_t clamp_sz(sz_t v, sz_t lo, sz_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/mmio_win_cfg.sv
module mmio_win_cfg import mmio_pe_pkg::*; #(
  parameter int N_WIN64 = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [ADDR_W-1:0]         cfg_wdata,
  output w64_cfg_t [N_WIN64-1:0]    w64,
  output w32_cfg_t                  w32,
  output logic                      tbl_we,
  output seg_t                      tbl_idx,
  output pe_t                       tbl_data
);
  localparam int SLOT_W = CFG_AW - 3;

  logic [1:0]        region;
  logic [SLOT_W-1:0] slot;
  logic              w32_sel, w64_sel;

  assign region   = cfg_addr[CFG_AW-1 -: 2];
  assign slot     = cfg_addr[CFG_AW-3:1];
  assign w32_sel  = cfg_we && (region == 2'd1) && (cfg_addr[CFG_AW-3:2] == '0);
  assign w64_sel  = cfg_we && (region == 2'd2);
  assign tbl_we   = cfg_we && (region == 2'd0);
  assign tbl_idx  = cfg_addr[SEG_W-1:0];
  assign tbl_data = cfg_wdata[PE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w32 <= '0;
    end else if (w32_sel) begin
      case (cfg_addr[1:0])
        2'd0: w32.base <= cfg_wdata;
        2'd1: begin
          w32.en <= cfg_wdata[0];
          w32.sz <= clamp_sz(cfg_wdata[8 +: SZ_W], sz_t'(SEG_W), sz_t'(W32_MAX_LOG2));
        end
        2'd2: w32.repl <= cfg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar w = 0; w < N_WIN64; w++) begin : g_w64
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        w64[w] <= '0;
      end else if (w64_sel && slot == SLOT_W'(w)) begin
        if (!cfg_addr[0]) begin
          w64[w].base <= cfg_wdata;
        end else begin
          w64[w].en       <= cfg_wdata[0];
          w64[w].seg_mode <= cfg_wdata[1];
          w64[w].sz       <= clamp_sz(cfg_wdata[8 +: SZ_W], sz_t'(W64_MIN_LOG2), sz_t'(ADDR_W-1));
          w64[w].pe       <= cfg_wdata[16 +: PE_W];
        end
      end
    end
  end
endmodule

// File: rtl/mmio_win64_match.sv
module mmio_win64_match import mmio_pe_pkg::*; (
  input  addr_t    addr,
  input  w64_cfg_t cfg,
  output logic     hit,
  output pe_t      pe
);
  assign hit = cfg.en && in_region(addr, cfg.base, cfg.sz);
  assign pe  = cfg.seg_mode ? pe_t'(seg_of(addr, cfg.sz)) : cfg.pe;
endmodule

// File: rtl/mmio_win32_xlate.sv
module mmio_win32_xlate import mmio_pe_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tbl_we,
  input  seg_t     tbl_idx,
  input  pe_t      tbl_data,
  input  addr_t    addr,
  input  w32_cfg_t cfg,
  output logic     hit,
  output pe_t      pe,
  output addr_t    pci_addr,
  output addr_t    mask
);
  localparam int N_SEG = 1 << SEG_W;

  pe_t seg_pe [N_SEG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SEG; i++) seg_pe[i] <= '0;
    end else if (tbl_we) begin
      seg_pe[tbl_idx] <= tbl_data;
    end
  end

  assign mask     = low_mask(cfg.sz);
  assign hit      = cfg.en && in_region(addr, cfg.base, cfg.sz);
  assign pe       = seg_pe[seg_of(addr, cfg.sz)];
  assign pci_addr = (cfg.repl & ~mask) | (addr & mask);
endmodule

// File: rtl/mmio_pe_decoder.sv
module mmio_pe_decoder import mmio_pe_pkg::*; #(
  parameter int N_WIN64 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] pci_addr,
  output logic [PE_W-1:0]   pe
);
  w64_cfg_t [N_WIN64-1:0] w64;
  w32_cfg_t               w32;
  logic                   tbl_we;
  seg_t                   tbl_idx;
  pe_t                    tbl_data;

  addr_t                  req_q;
  logic [N_WIN64-1:0]     win64_hits;
  logic [N_WIN64-1:0]     grant64;
  logic [N_WIN64-1:0]     en_vec;
  pe_t                    pe64 [N_WIN64];
  pe_t                    sel_pe64;
  logic                   any64, use32;
  logic                   w32_hit;
  pe_t                    w32_pe;
  addr_t                  w32_pci, w32_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_addr;
  end

  mmio_win_cfg #(.N_WIN64(N_WIN64)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .w64(w64), .w32(w32),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data)
  );

  for (genvar w = 0; w < N_WIN64; w++) begin : g_match
    mmio_win64_match u_m (
      .addr(req_q), .cfg(w64[w]), .hit(win64_hits[w]), .pe(pe64[w])
    );
    assign en_vec[w] = w64[w].en;
  end

  mmio_win32_xlate u_w32 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_data(tbl_data), .addr(req_q), .cfg(w32),
    .hit(w32_hit), .pe(w32_pe), .pci_addr(w32_pci), .mask(w32_mask)
  );

  // lowest index wins
  always_comb begin
    logic found;
    found    = 1'b0;
    grant64  = '0;
    sel_pe64 = '0;
    for (int i = 0; i < N_WIN64; i++) begin
      if (win64_hits[i] && !found) begin
        found      = 1'b1;
        grant64[i] = 1'b1;
        sel_pe64   = pe64[i];
      end
    end
  end

  assign any64 = |win64_hits;
  assign use32 = !any64 && w32_hit;

  assign hit      = any64 || w32_hit;
  assign pe       = any64 ? sel_pe64 : (use32 ? w32_pe  : '0);
  assign pci_addr = any64 ? req_q    : (use32 ? w32_pci : '0);
endmodule

// File: rtl/mmio_pe_decoder_chk.sv
module mmio_pe_decoder_chk import mmio_pe_pkg::*; #(
  parameter int N_WIN64 = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [ADDR_W-1:0]  req_q,
  input logic               hit,
  input logic [ADDR_W-1:0]  pci_addr,
  input logic [PE_W-1:0]    pe,
  input logic [N_WIN64-1:0] win64_hits,
  input logic [N_WIN64-1:0] grant64,
  input logic [N_WIN64-1:0] en_vec,
  input logic               any64,
  input logic               use32,
  input logic [ADDR_W-1:0]  w32_mask
);
  logic up_q;
  always_ff @(posedge clk) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  AST_INPUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> req_q == $past(req_addr)); // R2
  AST_MISS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (pe == '0 && pci_addr == '0)); // R13
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant64)); // R8
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (((grant64 - N_WIN64'(1)) & win64_hits) == '0)); // R8
  AST_W64_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    any64 |-> pci_addr == req_q); // R5
  AST_W32_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    any64 |-> !use32); // R9
  AST_W32_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    use32 |-> ((pci_addr ^ req_q) & w32_mask) == '0); // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (win64_hits & ~en_vec) == '0); // R14
endmodule

bind mmio_pe_decoder mmio_pe_decoder_chk #(.N_WIN64(N_WIN64)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_q(req_q),
  .hit(hit), .pci_addr(pci_addr), .pe(pe), .win64_hits(win64_hits),
  .grant64(grant64), .en_vec(en_vec), .any64(any64), .use32(use32),
  .w32_mask(w32_mask)
);

// File: tb/mmio_pe_decoder_test.sv
`timescale 1ns/1ps
module mmio_pe_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] req_addr = '0;
  logic        hit;
  logic [63:0] pci_addr;
  logic [7:0]  pe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mmio_pe_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_addr(req_addr),
    .hit(hit), .pci_addr(pci_addr), .pe(pe)
  );

  function automatic logic [63:0] ctl64(bit en, bit seg, int sz, logic [7:0] p);
    return (64'(p) << 16) | (64'(sz & 63) << 8) | (64'(seg) << 1) | 64'(en);
  endfunction

  function automatic logic [63:0] ctl32(bit en, int sz);
    return (64'(sz & 63) << 8) | 64'(en);
  endfunction

  task automatic cfg_write(logic [9:0] a, logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_out(string tag, logic eh, logic [7:0] ep, logic [63:0] ea);
    checks++;
    if (hit !== eh || pe !== ep || pci_addr !== ea) begin
      failures++;
      $display("FAIL %s: actual hit=%0b pe=%02h pci=%016h expected hit=%0b pe=%02h pci=%016h",
               tag, hit, pe, pci_addr, eh, ep, ea);
    end
  endtask

  task automatic lookup(logic [63:0] a, string tag, logic eh, logic [7:0] ep, logic [63:0] ea);
    @(negedge clk);
    req_addr = a;
    @(posedge clk);
    @(negedge clk);
    expect_out(tag, eh, ep, ea);
  endtask

  task automatic t_reset;
    lookup(64'h0000_0000_8000_0000, "R1 reset miss", 0, 8'h00, 64'h0);
    lookup(64'h0000_0010_0000_0000, "R1 reset miss high", 0, 8'h00, 64'h0);
  endtask

  task automatic t_unseg;
    cfg_write(10'h200, 64'h0000_0010_0000_1234);
    cfg_write(10'h201, ctl64(1, 0, 28, 8'h33));
    lookup(64'h0000_0010_0ABC_DEF0, "R6 R5 R4 unsegmented", 1, 8'h33, 64'h0000_0010_0ABC_DEF0);
    lookup(64'h0000_0010_0FFF_FFFF, "R4 top edge", 1, 8'h33, 64'h0000_0010_0FFF_FFFF);
    lookup(64'h0000_0010_1000_0000, "R13 just above", 0, 8'h00, 64'h0);
    lookup(64'h0000_000F_FFFF_FFFF, "R13 just below", 0, 8'h00, 64'h0);
  endtask

  task automatic t_latency;
    lookup(64'h5, "R2 prior miss", 0, 8'h00, 64'h0);
    @(negedge clk);
    req_addr = 64'h0000_0010_0ABC_DEF0;
    #2;
    expect_out("R2 held before edge", 0, 8'h00, 64'h0);
    @(posedge clk);
    @(negedge clk);
    expect_out("R2 after edge", 1, 8'h33, 64'h0000_0010_0ABC_DEF0);
  endtask

  task automatic t_clamp;
    cfg_write(10'h201, ctl64(1, 0, 20, 8'h33));
    lookup(64'h0000_0010_0800_0000, "R4 size clamped to 28", 1, 8'h33, 64'h0000_0010_0800_0000);
  endtask

  task automatic t_segmented;
    cfg_write(10'h202, 64'h0000_0020_0000_0000);
    cfg_write(10'h203, ctl64(1, 1, 32, 8'h99));
    lookup(64'h0000_0020_0500_0007, "R7 segment 5", 1, 8'h05, 64'h0000_0020_0500_0007);
    lookup(64'h0000_0020_FF00_0000, "R7 segment 255", 1, 8'hFF, 64'h0000_0020_FF00_0000);
    lookup(64'h0000_0020_00FF_FFFF, "R7 segment 0", 1, 8'h00, 64'h0000_0020_00FF_FFFF);
  endtask

  task automatic t_priority64;
    cfg_write(10'h204, 64'h0000_0020_0000_0000);
    cfg_write(10'h205, ctl64(1, 0, 28, 8'h77));
    lookup(64'h0000_0020_0500_0007, "R8 window1 over window2", 1, 8'h05, 64'h0000_0020_0500_0007);
    cfg_write(10'h206, 64'h0000_0030_0000_0000);
    cfg_write(10'h207, ctl64(1, 0, 28, 8'h44));
    cfg_write(10'h20A, 64'h0000_0030_0000_0000);
    cfg_write(10'h20B, ctl64(1, 0, 30, 8'h55));
    lookup(64'h0000_0030_0000_0010, "R8 window3 over window5", 1, 8'h44, 64'h0000_0030_0000_0010);
    lookup(64'h0000_0030_1000_0000, "R8 only window5", 1, 8'h55, 64'h0000_0030_1000_0000);
    cfg_write(10'h207, ctl64(0, 0, 28, 8'h44));
    lookup(64'h0000_0030_0000_0010, "R14 disabled window3", 1, 8'h55, 64'h0000_0030_0000_0010);
  endtask

  task automatic t_w32;
    cfg_write(10'h000, 64'h11);
    cfg_write(10'h003, 64'h2A);
    cfg_write(10'h0FF, 64'hC3);
    cfg_write(10'h100, 64'h0000_03FE_8000_0000);
    cfg_write(10'h102, 64'h0000_0000_8000_0000);
    cfg_write(10'h101, ctl32(1, 31));
    lookup(64'h0000_03FE_8180_0010, "R10 R11 segment 3", 1, 8'h2A, 64'h0000_0000_8180_0010);
    lookup(64'h0000_03FE_8000_0000, "R11 segment 0", 1, 8'h11, 64'h0000_0000_8000_0000);
    lookup(64'h0000_03FE_FFFF_0000, "R12 top 64KB", 1, 8'hC3, 64'h0000_0000_FFFF_0000);
    lookup(64'h0000_03FF_0000_0000, "R13 above 32-bit window", 0, 8'h00, 64'h0);
  endtask

  task automatic t_w64_over_w32;
    cfg_write(10'h20C, 64'h0000_03FE_8000_0000);
    cfg_write(10'h20D, ctl64(1, 0, 28, 8'h66));
    lookup(64'h0000_03FE_8180_0010, "R9 64-bit window first", 1, 8'h66, 64'h0000_03FE_8180_0010);
    lookup(64'h0000_03FE_9000_0000, "R9 falls to 32-bit window", 1, 8'h00, 64'h0000_0000_9000_0000);
  endtask

  task automatic t_ignored;
    cfg_write(10'h3FF, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg_write(10'h300, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg_write(10'h2F1, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg_write(10'h103, 64'hFFFF_FFFF_FFFF_FFFF);
    lookup(64'h0000_03FE_8180_0010, "R3 unmapped writes ignored w64", 1, 8'h66, 64'h0000_03FE_8180_0010);
    lookup(64'h0000_03FE_9000_0000, "R3 unmapped writes ignored w32", 1, 8'h00, 64'h0000_0000_9000_0000);
    lookup(64'h0000_0050_0000_0000, "R3 no new window", 0, 8'h00, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unseg();
    t_latency();
    t_clamp();
    t_segmented();
    t_priority64();
    t_w32();
    t_w64_over_w32();
    t_ignored();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule